// File: doc/BRIEF.md
# Scanline Timing Generator

This block keeps the horizontal and vertical beam position of a console picture processor, counted in master-clock units. The horizontal count moves up by two on every clock. At the end of a line it returns to zero and the line count moves on. At the end of a frame the line count returns to zero and the field bit flips. From the next-state position the block derives registered single-cycle event strobes. These mark line start, frame start, sprite-table address reload, render start and sprite-configuration latch. It also maps the raw horizontal count onto a pixel dot index.

A normal line is 1364 clocks long. One line per frame is shortened to 1360 clocks: the line at SHORT_LINE (default 240) in field 1, when the region is NTSC and interlace is off. The dot index absorbs two stretched dots late in each line, so three horizontal positions map to the same dot there. On the shortened line the dot index is the plain quarter of the count.

Every output is registered and valid in the same cycle as the counters, so downstream logic can compare them directly. Line counts and event lines are parameters. The defaults are 262 or 312 lines, reload on line 225, or on line 240 with overscan.

Top module: `scan_timing_gen`

## Requirements
- R1: While rst is high, and in the first cycle after it falls, h_count, v_count, field, dot_idx, all strobes, spr_addr, spr_first, spr_cfg_q and interlace_q are zero.
- R2: h_count grows by exactly 2 each clock and is always even. From LINE_CLKS-2 (1362) it returns to 0.
- R3: When h_count returns to 0, v_count increments. The last line is LINES_NTSC-1 when region_pal=0 and LINES_PAL-1 when region_pal=1, plus one more line when interlace=1 and field=0. After the last line v_count returns to 0 and field toggles.
- R4: line_stb is high exactly in the cycles where h_count=0. frame_stb is high exactly where h_count=0 and v_count=0, apart from the reset state.
- R5: dot_idx = (h - 2*[h>1292] - 2*[h>1310]) >> 2 for the current h_count on every normal line. Examples: h=1292,1294,1296 give 323, and h=1310,1312,1314 give 327.
- R6: render_stb is high exactly when h_count=512. At h_count=1152, cfg_stb pulses and spr_cfg_q takes spr_cfg_in. Changes of spr_cfg_in at any other point do not alter spr_cfg_q.
- R7: At h_count=10 on line RELOAD_LINE (overscan=0), when disp_off=0, spr_addr becomes {spr_base,0} and reload_stb pulses. When disp_off=1 the reload does not happen and spr_addr keeps its value.
- R8: With overscan=1 the reload line is RELOAD_LINE_OS instead. spr_first becomes spr_addr[8:2] when spr_rotate=1, and 0 when spr_rotate=0.
- R9: At frame start, interlace_q takes interlace only if the new field is 0. In field 1 it is left unchanged.
- R10: When region_pal=0, interlace=0, field=1 and v_count=SHORT_LINE, the line wraps from h=1358 to 0, and dot_idx = h>>2 (h=1300 gives 325). On PAL that line runs to 1362 (h=1300 gives 324).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| region_pal | input | 1 | 0 = NTSC line count and short line, 1 = PAL |
| interlace | input | 1 | interlace enable |
| overscan | input | 1 | selects the later reload line |
| disp_off | input | 1 | display disabled, blocks sprite address reload |
| spr_base | input | 9 | sprite table base address |
| spr_rotate | input | 1 | sprite priority rotation enable |
| spr_cfg_in | input | 8 | sprite size/name/tile-base settings to latch |
| h_count | output | 11 | horizontal position in master clocks |
| v_count | output | 9 | line number |
| field | output | 1 | field bit |
| dot_idx | output | 9 | pixel dot index |
| line_stb | output | 1 | line start pulse |
| frame_stb | output | 1 | frame start pulse |
| reload_stb | output | 1 | sprite address reload pulse |
| render_stb | output | 1 | render start pulse |
| cfg_stb | output | 1 | sprite config latch pulse |
| spr_addr | output | 10 | reloaded sprite table address |
| spr_first | output | 7 | first-sprite index |
| spr_cfg_q | output | 8 | latched sprite configuration |
| interlace_q | output | 1 | interlace setting latched at frame start |

## Verification
The bench walks the dot index across both stretched-dot regions. A mapping with a wrong threshold or a wrong comparison would give one dot too few or too many there. It checks that the shortened line wraps four clocks early only in NTSC field 1 with interlace off: a design that shortens it in PAL, or never shortens it, lands on 1360 or on 0 at the wrong time. It checks the reload line under overscan and display-disable and with and without rotation; an error shows up as a stale or unexpected spr_addr or spr_first. It also checks that the extra interlaced line appears only in field 0 and that interlace_q ignores frame starts in field 1.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef struct packed {
    logic line;
    logic frame;
    logic reload;
    logic render;
    logic cfg;
  } strobe_t;
endpackage

// File: rtl/scan_counters.sv
module scan_counters #(
  parameter int HW         = 11,
  parameter int VW         = 9,
  parameter int LINE_CLKS  = 1364,
  parameter int SHORT_CLKS = 1360,
  parameter int SHORT_LINE = 240,
  parameter int LINES_NTSC = 262,
  parameter int LINES_PAL  = 312
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          region_pal,
  input  logic          interlace,
  output logic [HW-1:0] h_q,
  output logic [VW-1:0] v_q,
  output logic          f_q,
  output logic [HW-1:0] h_n,
  output logic [VW-1:0] v_n,
  output logic          f_n,
  output logic          short_n
);
  localparam logic [HW-1:0] H_LAST_N = HW'(LINE_CLKS - 2);
  localparam logic [HW-1:0] H_LAST_S = HW'(SHORT_CLKS - 2);
  localparam logic [HW-1:0] H_STEP   = HW'(2);
  localparam logic [VW-1:0] V_LAST_N = VW'(LINES_NTSC - 1);
  localparam logic [VW-1:0] V_LAST_P = VW'(LINES_PAL - 1);
  localparam logic [VW-1:0] V_SHORT  = VW'(SHORT_LINE);

  logic          short_cur;
  logic [HW-1:0] h_last;
  logic [VW-1:0] v_last;

  always_comb begin
    short_cur = !region_pal && !interlace && f_q && (v_q == V_SHORT);
    h_last    = short_cur ? H_LAST_S : H_LAST_N;
    v_last    = region_pal ? V_LAST_P : V_LAST_N;
    if (interlace && !f_q) v_last = v_last + 1'b1;
    h_n = h_q + H_STEP;
    v_n = v_q;
    f_n = f_q;
    if (h_q >= h_last) begin
      h_n = '0;
      if (v_q >= v_last) begin
        v_n = '0;
        f_n = ~f_q;
      end else begin
        v_n = v_q + 1'b1;
      end
    end
    short_n = !region_pal && !interlace && f_n && (v_n == V_SHORT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= '0;
      v_q <= '0;
      f_q <= 1'b0;
    end else begin
      h_q <= h_n;
      v_q <= v_n;
      f_q <= f_n;
    end
  end
endmodule

// File: rtl/scan_dot_map.sv
module scan_dot_map #(
  parameter int HW  = 11,
  parameter int DW  = 9,
  parameter int ST1 = 1292,
  parameter int ST2 = 1310
) (
  input  logic [HW-1:0] h,
  input  logic          short_line,
  output logic [DW-1:0] dot
);
  localparam logic [HW-1:0] T1  = HW'(ST1);
  localparam logic [HW-1:0] T2  = HW'(ST2);
  localparam logic [HW-1:0] TWO = HW'(2);

  logic [HW-1:0] adj;

  always_comb begin
    adj = h;
    if (!short_line) begin
      if (h > T1) adj = adj - TWO;
      if (h > T2) adj = adj - TWO;
    end
    dot = adj[DW+1:2];
  end
endmodule

// File: rtl/scan_events.sv
module scan_events
  import scan_pkg::*;
#(
  parameter int HW             = 11,
  parameter int VW             = 9,
  parameter int BW             = 9,
  parameter int FW             = 7,
  parameter int CW             = 8,
  parameter int H_RELOAD       = 10,
  parameter int H_RENDER       = 512,
  parameter int H_CFG          = 1152,
  parameter int RELOAD_LINE    = 225,
  parameter int RELOAD_LINE_OS = 240
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_n,
  input  logic [VW-1:0] v_n,
  input  logic          f_n,
  input  logic          interlace,
  input  logic          overscan,
  input  logic          disp_off,
  input  logic [BW-1:0] spr_base,
  input  logic          spr_rotate,
  input  logic [CW-1:0] cfg_in,
  output strobe_t       stb,
  output logic [BW:0]   spr_addr,
  output logic [FW-1:0] spr_first,
  output logic [CW-1:0] cfg_q,
  output logic          il_q
);
  localparam int AW = BW + 1;
  localparam logic [HW-1:0] HR_RELOAD = HW'(H_RELOAD);
  localparam logic [HW-1:0] HR_RENDER = HW'(H_RENDER);
  localparam logic [HW-1:0] HR_CFG    = HW'(H_CFG);
  localparam logic [VW-1:0] VL_STD    = VW'(RELOAD_LINE);
  localparam logic [VW-1:0] VL_OS     = VW'(RELOAD_LINE_OS);

  logic          at_line, at_frame, at_reload, at_render, at_cfg;
  logic [AW-1:0] addr_new;

  always_comb begin
    at_line   = (h_n == '0);
    at_frame  = at_line && (v_n == '0);
    at_render = (h_n == HR_RENDER);
    at_cfg    = (h_n == HR_CFG);
    at_reload = !disp_off && (h_n == HR_RELOAD) &&
                (v_n == (overscan ? VL_OS : VL_STD));
    addr_new  = {spr_base, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb       <= '0;
      spr_addr  <= '0;
      spr_first <= '0;
      cfg_q     <= '0;
      il_q      <= 1'b0;
    end else begin
      stb.line   <= at_line;
      stb.frame  <= at_frame;
      stb.reload <= at_reload;
      stb.render <= at_render;
      stb.cfg    <= at_cfg;
      if (at_reload) begin
        spr_addr  <= addr_new;
        spr_first <= spr_rotate ? addr_new[FW+1:2] : '0;
      end
      if (at_cfg) cfg_q <= cfg_in;
      if (at_frame && !f_n) il_q <= interlace;
    end
  end
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_pkg::*;
#(
  parameter int HW             = 11,
  parameter int VW             = 9,
  parameter int BW             = 9,
  parameter int FW             = 7,
  parameter int CW             = 8,
  parameter int LINE_CLKS      = 1364,
  parameter int SHORT_CLKS     = 1360,
  parameter int SHORT_LINE     = 240,
  parameter int LINES_NTSC     = 262,
  parameter int LINES_PAL      = 312,
  parameter int STRETCH_A      = 1292,
  parameter int STRETCH_B      = 1310,
  parameter int H_RELOAD       = 10,
  parameter int H_RENDER       = 512,
  parameter int H_CFG          = 1152,
  parameter int RELOAD_LINE    = 225,
  parameter int RELOAD_LINE_OS = 240
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          region_pal,
  input  logic          interlace,
  input  logic          overscan,
  input  logic          disp_off,
  input  logic [BW-1:0] spr_base,
  input  logic          spr_rotate,
  input  logic [CW-1:0] spr_cfg_in,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] v_count,
  output logic          field,
  output logic [HW-3:0] dot_idx,
  output logic          line_stb,
  output logic          frame_stb,
  output logic          reload_stb,
  output logic          render_stb,
  output logic          cfg_stb,
  output logic [BW:0]   spr_addr,
  output logic [FW-1:0] spr_first,
  output logic [CW-1:0] spr_cfg_q,
  output logic          interlace_q
);
  localparam int DW = HW - 2;

  logic [HW-1:0] h_n;
  logic [VW-1:0] v_n;
  logic          f_n;
  logic          short_n;
  logic [DW-1:0] dot_n;
  strobe_t       stb;

  scan_counters #(
    .HW(HW), .VW(VW), .LINE_CLKS(LINE_CLKS), .SHORT_CLKS(SHORT_CLKS),
    .SHORT_LINE(SHORT_LINE), .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL)
  ) u_cnt (
    .clk(clk), .rst(rst), .region_pal(region_pal), .interlace(interlace),
    .h_q(h_count), .v_q(v_count), .f_q(field),
    .h_n(h_n), .v_n(v_n), .f_n(f_n), .short_n(short_n)
  );

  scan_dot_map #(
    .HW(HW), .DW(DW), .ST1(STRETCH_A), .ST2(STRETCH_B)
  ) u_dot (
    .h(h_n), .short_line(short_n), .dot(dot_n)
  );

  always_ff @(posedge clk) begin
    if (rst) dot_idx <= '0;
    else     dot_idx <= dot_n;
  end

  scan_events #(
    .HW(HW), .VW(VW), .BW(BW), .FW(FW), .CW(CW),
    .H_RELOAD(H_RELOAD), .H_RENDER(H_RENDER), .H_CFG(H_CFG),
    .RELOAD_LINE(RELOAD_LINE), .RELOAD_LINE_OS(RELOAD_LINE_OS)
  ) u_evt (
    .clk(clk), .rst(rst), .h_n(h_n), .v_n(v_n), .f_n(f_n),
    .interlace(interlace), .overscan(overscan), .disp_off(disp_off),
    .spr_base(spr_base), .spr_rotate(spr_rotate), .cfg_in(spr_cfg_in),
    .stb(stb), .spr_addr(spr_addr), .spr_first(spr_first),
    .cfg_q(spr_cfg_q), .il_q(interlace_q)
  );

  assign line_stb   = stb.line;
  assign frame_stb  = stb.frame;
  assign reload_stb = stb.reload;
  assign render_stb = stb.render;
  assign cfg_stb    = stb.cfg;
endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk #(
  parameter int HW         = 11,
  parameter int VW         = 9,
  parameter int AW         = 10,
  parameter int LINE_CLKS  = 1364,
  parameter int SHORT_CLKS = 1360,
  parameter int SHORT_LINE = 240,
  parameter int H_RENDER   = 512
) (
  input logic          clk,
  input logic          rst,
  input logic          region_pal,
  input logic          interlace,
  input logic [HW-1:0] h_count,
  input logic [VW-1:0] v_count,
  input logic          field,
  input logic [HW-3:0] dot_idx,
  input logic          line_stb,
  input logic          frame_stb,
  input logic          reload_stb,
  input logic          render_stb,
  input logic [AW-1:0] spr_addr
);
  localparam logic [HW-1:0] H_MAX   = HW'(LINE_CLKS);
  localparam logic [HW-1:0] H_SLAST = HW'(SHORT_CLKS - 2);
  localparam logic [HW-1:0] H_REN   = HW'(H_RENDER);
  localparam logic [HW-1:0] H_TWO   = HW'(2);
  localparam logic [VW-1:0] V_SHORT = VW'(SHORT_LINE);
  localparam logic [HW-3:0] D_MAX   = (HW-2)'((LINE_CLKS - 2) / 4);

  // R2
  h_even_chk: assert property (@(posedge clk) disable iff (rst)
    (!h_count[0] && (h_count < H_MAX)));

  // R2
  h_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((h_count == $past(h_count) + H_TWO) || (h_count == '0)));

  // R3
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (h_count != '0) |-> $stable(v_count));

  // R3
  field_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(field) |-> ((h_count == '0) && (v_count == '0)));

  // R4
  line_stb_chk: assert property (@(posedge clk) disable iff (rst)
    line_stb |-> (h_count == '0));

  // R4
  frame_stb_chk: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> (line_stb && (v_count == '0)));

  // R5
  dot_range_chk: assert property (@(posedge clk) disable iff (rst)
    (dot_idx <= D_MAX));

  // R6
  render_chk: assert property (@(posedge clk) disable iff (rst)
    render_stb |-> (h_count == H_REN));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(spr_addr) |-> reload_stb);

  // R10
  short_chk: assert property (@(posedge clk) disable iff (rst)
    ((h_count == H_SLAST) && !region_pal && !interlace && field &&
     (v_count == V_SHORT)) |=> (h_count == '0));
endmodule

bind scan_timing_gen scan_timing_chk #(
  .HW(HW), .VW(VW), .AW(BW + 1), .LINE_CLKS(LINE_CLKS),
  .SHORT_CLKS(SHORT_CLKS), .SHORT_LINE(SHORT_LINE), .H_RENDER(H_RENDER)
) u_chk (
  .clk(clk), .rst(rst), .region_pal(region_pal), .interlace(interlace),
  .h_count(h_count), .v_count(v_count), .field(field), .dot_idx(dot_idx),
  .line_stb(line_stb), .frame_stb(frame_stb), .reload_stb(reload_stb),
  .render_stb(render_stb), .spr_addr(spr_addr)
);

// File: tb/scan_timing_gen_tb.sv
module scan_timing_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {h_count, expected dot} on a normal line
  localparam logic [19:0] DOT_VEC [NVEC] = '{
    {11'd0, 9'd0},      {11'd2, 9'd0},      {11'd4, 9'd1},
    {11'd510, 9'd127},  {11'd1290, 9'd322}, {11'd1292, 9'd323},
    {11'd1294, 9'd323}, {11'd1296, 9'd323}, {11'd1298, 9'd324},
    {11'd1310, 9'd327}, {11'd1312, 9'd327}, {11'd1314, 9'd327},
    {11'd1316, 9'd328}, {11'd1362, 9'd339}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        region_pal = 1'b0, interlace = 1'b0, overscan = 1'b0;
  logic        disp_off = 1'b0, spr_rotate = 1'b0;
  logic [8:0]  spr_base = '0;
  logic [7:0]  spr_cfg_in = '0;
  logic [10:0] h_count;
  logic [8:0]  v_count;
  logic        field;
  logic [8:0]  dot_idx;
  logic        line_stb, frame_stb, reload_stb, render_stb, cfg_stb;
  logic [9:0]  spr_addr;
  logic [6:0]  spr_first;
  logic [7:0]  spr_cfg_q;
  logic        interlace_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_timing_gen #(
    .LINES_NTSC(12), .LINES_PAL(15), .SHORT_LINE(8),
    .RELOAD_LINE(5), .RELOAD_LINE_OS(8)
  ) u_dut (
    .clk(clk), .rst(rst), .region_pal(region_pal), .interlace(interlace),
    .overscan(overscan), .disp_off(disp_off), .spr_base(spr_base),
    .spr_rotate(spr_rotate), .spr_cfg_in(spr_cfg_in),
    .h_count(h_count), .v_count(v_count), .field(field), .dot_idx(dot_idx),
    .line_stb(line_stb), .frame_stb(frame_stb), .reload_stb(reload_stb),
    .render_stb(render_stb), .cfg_stb(cfg_stb), .spr_addr(spr_addr),
    .spr_first(spr_first), .spr_cfg_q(spr_cfg_q), .interlace_q(interlace_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (v=%0d h=%0d)",
               req, act, exp, v_count, h_count);
    end
  endtask

  task automatic wait_hv(input int v, input int h);
    int guard = 0;
    @(negedge clk);
    while (!((int'(v_count) == v) && (int'(h_count) == h)) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 20000) chk("wait position", int'(v_count), v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 h in reset", int'(h_count), 0);
    rst = 1'b0;
    #1;
    // R1 first cycle after reset
    chk("R1 h", int'(h_count), 0);
    chk("R1 v", int'(v_count), 0);
    chk("R1 field", int'(field), 0);
    chk("R1 dot", int'(dot_idx), 0);
    chk("R1 strobes", int'({line_stb, frame_stb, reload_stb, render_stb, cfg_stb}), 0);
    chk("R1 spr_addr", int'(spr_addr), 0);
    chk("R1 cfg_q", int'(spr_cfg_q), 0);
    chk("R1 interlace_q", int'(interlace_q), 0);

    // R5 dot table on line 1
    for (int i = 0; i < NVEC; i++) begin
      wait_hv(1, int'(DOT_VEC[i][19:9]));
      chk("R5 dot", int'(dot_idx), int'(DOT_VEC[i][8:0]));
    end
    // R2 R4 line wrap
    @(negedge clk);
    chk("R2 h wrap", int'(h_count), 0);
    chk("R3 v inc", int'(v_count), 2);
    chk("R4 line_stb", int'(line_stb), 1);
    chk("R4 no frame_stb", int'(frame_stb), 0);
    @(negedge clk);
    chk("R2 h step", int'(h_count), 2);
    chk("R4 line_stb low", int'(line_stb), 0);

    // R6 render and config latch
    wait_hv(2, 512);
    chk("R6 render_stb", int'(render_stb), 1);
    @(negedge clk);
    chk("R6 render_stb low", int'(render_stb), 0);
    wait_hv(2, 1100);
    spr_cfg_in = 8'hA5;
    wait_hv(2, 1150);
    chk("R6 cfg before latch", int'(spr_cfg_q), 0);
    @(negedge clk);
    chk("R6 cfg_stb", int'(cfg_stb), 1);
    chk("R6 cfg latched", int'(spr_cfg_q), 8'hA5);
    wait_hv(2, 1200);
    spr_cfg_in = 8'h3C;
    wait_hv(2, 1362);
    chk("R6 cfg ignores late change", int'(spr_cfg_q), 8'hA5);

    // R7 R8 reload with rotation
    wait_hv(3, 0);
    spr_base = 9'h1F3; spr_rotate = 1'b1; disp_off = 1'b0; overscan = 1'b0;
    wait_hv(5, 8);
    chk("R7 addr before reload", int'(spr_addr), 0);
    @(negedge clk);
    chk("R7 reload_stb", int'(reload_stb), 1);
    chk("R7 addr reload", int'(spr_addr), 10'h3E6);
    chk("R8 first rotate", int'(spr_first), 7'h79);

    // R7 display off blocks the reload
    wait_hv(6, 0);
    disp_off = 1'b1; overscan = 1'b1; spr_base = 9'h055; spr_rotate = 1'b0;
    wait_hv(8, 12);
    chk("R7 disabled addr kept", int'(spr_addr), 10'h3E6);
    chk("R7 disabled first kept", int'(spr_first), 7'h79);

    // R3 frame wrap, 12 lines
    wait_hv(11, 1362);
    chk("R3 field before wrap", int'(field), 0);
    @(negedge clk);
    chk("R3 v wrap", int'(v_count), 0);
    chk("R3 field toggles", int'(field), 1);
    chk("R4 frame_stb", int'(frame_stb), 1);
    chk("R9 interlace_q", int'(interlace_q), 0);

    // frame B: field 1, NTSC
    wait_hv(0, 2);
    disp_off = 1'b0;
    wait_hv(5, 12);
    chk("R8 overscan no reload on std line", int'(spr_addr), 10'h3E6);
    wait_hv(8, 12);
    chk("R8 overscan reload", int'(spr_addr), 10'h0AA);
    chk("R8 first no rotate", int'(spr_first), 0);
    wait_hv(8, 1300);
    chk("R10 short line dot", int'(dot_idx), 325);
    wait_hv(8, 1358);
    @(negedge clk);
    chk("R10 short wrap h", int'(h_count), 0);
    chk("R10 short wrap v", int'(v_count), 9);
    wait_hv(10, 0);
    interlace = 1'b1;
    wait_hv(11, 1362);
    @(negedge clk);
    chk("R3 field back to 0", int'(field), 0);
    chk("R3 v wrap field1", int'(v_count), 0);
    chk("R9 latch in field 0", int'(interlace_q), 1);

    // frame C: interlace, field 0 -> extra line
    wait_hv(11, 1362);
    @(negedge clk);
    chk("R3 extra interlaced line", int'(v_count), 12);
    interlace = 1'b0;
    wait_hv(12, 1362);
    @(negedge clk);
    chk("R3 wrap after extra line", int'(v_count), 0);
    chk("R3 field 1 again", int'(field), 1);
    chk("R9 no latch in field 1", int'(interlace_q), 1);

    // frame D: PAL, field 1, no short line
    wait_hv(0, 2);
    region_pal = 1'b1;
    wait_hv(8, 1300);
    chk("R10 PAL dot normal", int'(dot_idx), 324);
    wait_hv(8, 1358);
    @(negedge clk);
    chk("R10 PAL line not shortened", int'(h_count), 1360);
    wait_hv(11, 1362);
    @(negedge clk);
    chk("R3 PAL continues past 12 lines", int'(v_count), 12);
    wait_hv(14, 1362);
    @(negedge clk);
    chk("R3 PAL wrap", int'(v_count), 0);
    chk("R3 PAL field", int'(field), 0);
    chk("R9 latch off in field 0", int'(interlace_q), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule